// File: doc/BRIEF.md
# MDIO Management Master

This block is a station-management master for Ethernet PHYs. Software sets a configuration register (framing clause, preamble on/off, MDC divider), loads a write-data register and then writes a command register. Each accepted command sends exactly one serial management frame on MDC/MDIO. The block generates MDC from the system clock. It optionally sends a 32-bit preamble of ones, then shifts out start, opcode, port address, register or device address, turnaround and 16 data bits, MSB first.

The same command register serves clause 22 and clause 45. The mode bit decides how the 2-bit opcode maps to wire bits. In clause 45 mode the register-address field goes on the wire as the device address. A clause 45 access takes two commands: an address frame carrying the register number from the write-data register, then a write or read frame. Reads release MDIO from the turnaround onward, check that the PHY drives the second turnaround bit low, and capture 16 data bits. Status is held in the data registers: a pending flag on the write-data register, and pending and valid flags on the read-data register.

Top module: `mdio_master`

## Requirements
- R1: After reset all registers read as zero, MDC is low, MDIO output-enable is low and the MDIO output is high.
- R2: MDC toggles only while a frame is in progress. Each MDC phase lasts the configured half-period in system clocks (config bits [15:8]; 0 counts as 1). Between frames MDC is low.
- R3: With the preamble bit (config bit 1) set, 32 ones precede the frame. With it clear, no preamble is sent.
- R4: In clause 22 mode (config bit 0 = 0) the start bits are 01. Opcode bit 0 of the command selects the operation: 0 sends a write with wire OP 01, and 1 sends a read with wire OP 10.
- R5: In clause 45 mode (config bit 0 = 1) the start bits are 00 and the wire OP equals the 2-bit opcode: 0 address, 1 write, 2 read with post-increment, 3 read. The command's register field is sent as the device address.
- R6: Write and address frames send, after the two address fields, the turnaround bits 10 followed by the write-data register value, MSB first.
- R7: Write-data status bit 16 (pending) is set when a write or address command is launched. It clears once the last bit has been shifted out.
- R8: On read frames the output-enable drops from the first turnaround bit to the end of the frame. 16 data bits are sampled on rising MDC edges, MSB first. Read status bit 17 (pending) is set and bit 16 (valid) is cleared at launch. At completion the data lands in bits [15:0] and pending clears.
- R9: If the PHY leaves the second turnaround bit high on a read, valid stays 0 when the read completes.
- R10: A command written while a frame is in progress is ignored. No frame is sent for it and neither status register changes because of it.
- R11: CSR word offsets: 0 config, 1 write data ([15:0] data), 2 command ([1:0] opcode, [12:8] port address, [20:16] register/device address; reads as 0), 3 read data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| csr_we_i | input | 1 | CSR write strobe |
| csr_addr_i | input | 2 | CSR word offset |
| csr_wdata_i | input | 32 | CSR write data |
| csr_rdata_o | output | 32 | CSR read data for csr_addr_i (combinational) |
| mdc_o | output | 1 | Management clock to PHYs |
| mdio_o | output | 1 | Serial data driven by the master |
| mdio_oe_o | output | 1 | Output-enable for mdio_o |
| mdio_i | input | 1 | Serial data seen on the MDIO wire |

## Verification
A fault in the bit counter or in the frame image shows as a wrong bit, or a wrong count of driven bits, within one MDC period of the fault. The bench captures every driven bit and compares the whole frame. A wrong release point or a misplaced sample shows only when the read completes, as wrong data or a wrong valid flag. Pending flags that are never set or never cleared show right after launch and right after the last MDC edge.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int PRE_W   = 32;
  localparam int FRAME_W = 32;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 5;
  localparam int BIT_W   = $clog2(PRE_W + FRAME_W);
  // frame positions counted from the end of the preamble
  localparam int POS_TA1 = 14;
  localparam int POS_TA2 = 15;
  localparam int POS_DAT = 16;

  typedef enum logic [1:0] {
    CSR_CFG  = 2'd0,
    CSR_WDAT = 2'd1,
    CSR_CMD  = 2'd2,
    CSR_RDAT = 2'd3
  } csr_sel_e;

  function automatic logic [FRAME_W-1:0] build_frame(
      input logic c45, input logic [1:0] opc,
      input logic [ADDR_W-1:0] prt, input logic [ADDR_W-1:0] rga,
      input logic [DATA_W-1:0] dat);
    logic [1:0] st, op;
    st = c45 ? 2'b00 : 2'b01;
    op = c45 ? opc : (opc[0] ? 2'b10 : 2'b01);
    return {st, op, prt, rga, 2'b10, dat};
  endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             mdc_o,
  output logic             rise_o,
  output logic             fall_o
);
  logic [DIV_W-1:0] cnt_q, hp;
  logic mdc_q, tick;

  assign hp     = (half_i == '0) ? DIV_W'(1) : half_i;
  assign tick   = run_i && (cnt_q == hp - DIV_W'(1));
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= ~mdc_q;
    end else begin
      cnt_q <= cnt_q + DIV_W'(1);
    end
  end
endmodule

// File: rtl/mdio_engine.sv
module mdio_engine
  import mdio_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               pre_en_i,
  input  logic               is_rd_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic               rise_i,
  input  logic               fall_i,
  input  logic               mdio_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               ta_ok_o,
  output logic [DATA_W-1:0]  rx_o,
  output logic               mdio_o,
  output logic               mdio_oe_o
);
  localparam logic [BIT_W-1:0] LAST    = BIT_W'(PRE_W + FRAME_W - 1);
  localparam logic [BIT_W-1:0] REL_IDX = BIT_W'(PRE_W + POS_TA1);
  localparam logic [BIT_W-1:0] TA2_IDX = BIT_W'(PRE_W + POS_TA2);
  localparam logic [BIT_W-1:0] DAT_IDX = BIT_W'(PRE_W + POS_DAT);

  logic               busy_q, done_q, rd_q, ta_err_q;
  logic [BIT_W-1:0]   idx_q;
  logic [FRAME_W-1:0] frame_q;
  logic [DATA_W-1:0]  rx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      rd_q     <= 1'b0;
      ta_err_q <= 1'b0;
      idx_q    <= '0;
      frame_q  <= '0;
      rx_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q   <= 1'b1;
        rd_q     <= is_rd_i;
        ta_err_q <= 1'b0;
        frame_q  <= frame_i;
        rx_q     <= '0;
        idx_q    <= pre_en_i ? '0 : BIT_W'(PRE_W);
      end else if (busy_q) begin
        if (rise_i && rd_q) begin
          if (idx_q == TA2_IDX && mdio_i) ta_err_q <= 1'b1;
          if (idx_q >= DAT_IDX) rx_q <= {rx_q[DATA_W-2:0], mdio_i};
        end
        if (fall_i) begin
          if (idx_q == LAST) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            idx_q <= idx_q + BIT_W'(1);
          end
        end
      end
    end
  end

  // preamble bits have idx below PRE_W; frame bit index counts down from MSB
  assign mdio_o    = !busy_q || (idx_q < BIT_W'(PRE_W)) ||
                     frame_q[~idx_q[$clog2(FRAME_W)-1:0]];
  assign mdio_oe_o = busy_q && !(rd_q && idx_q >= REL_IDX);
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign ta_ok_o   = !ta_err_q;
  assign rx_o      = rx_q;
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        csr_we_i,
  input  logic [1:0]  csr_addr_i,
  input  logic [31:0] csr_wdata_i,
  output logic [31:0] csr_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam int HALF_LSB = 8;

  logic              cfg_c45_q, cfg_pre_q;
  logic [DIV_W-1:0]  cfg_half_q;
  logic [DATA_W-1:0] wdat_q, rdat_q;
  logic              wr_pend_q, rd_pend_q, rd_valid_q;

  logic eng_busy, eng_done, eng_ta_ok, rise, fall, launch, cmd_rd;
  logic [DATA_W-1:0]  eng_rx;
  logic [FRAME_W-1:0] frame;
  csr_sel_e sel;

  assign sel    = csr_sel_e'(csr_addr_i);
  assign cmd_rd = cfg_c45_q ? csr_wdata_i[1] : csr_wdata_i[0];
  assign launch = csr_we_i && sel == CSR_CMD && !eng_busy && !wr_pend_q && !rd_pend_q;
  assign frame  = build_frame(cfg_c45_q, csr_wdata_i[1:0], csr_wdata_i[12:8],
                              csr_wdata_i[20:16], cmd_rd ? '1 : wdat_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_c45_q  <= 1'b0;
      cfg_pre_q  <= 1'b0;
      cfg_half_q <= '0;
      wdat_q     <= '0;
      rdat_q     <= '0;
      wr_pend_q  <= 1'b0;
      rd_pend_q  <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      if (csr_we_i && sel == CSR_CFG) begin
        cfg_c45_q  <= csr_wdata_i[0];
        cfg_pre_q  <= csr_wdata_i[1];
        cfg_half_q <= csr_wdata_i[HALF_LSB +: DIV_W];
      end
      if (csr_we_i && sel == CSR_WDAT) wdat_q <= csr_wdata_i[DATA_W-1:0];
      if (launch) begin
        if (cmd_rd) begin
          rd_pend_q  <= 1'b1;
          rd_valid_q <= 1'b0;
        end else begin
          wr_pend_q <= 1'b1;
        end
      end else if (eng_done) begin
        if (rd_pend_q) begin
          rd_pend_q  <= 1'b0;
          rd_valid_q <= eng_ta_ok;
          rdat_q     <= eng_rx;
        end else begin
          wr_pend_q <= 1'b0;
        end
      end
    end
  end

  always_comb begin
    csr_rdata_o = '0;
    unique case (sel)
      CSR_CFG: begin
        csr_rdata_o[0] = cfg_c45_q;
        csr_rdata_o[1] = cfg_pre_q;
        csr_rdata_o[HALF_LSB +: DIV_W] = cfg_half_q;
      end
      CSR_WDAT: csr_rdata_o = {15'd0, wr_pend_q, wdat_q};
      CSR_RDAT: csr_rdata_o = {14'd0, rd_pend_q, rd_valid_q, rdat_q};
      default:  csr_rdata_o = '0;
    endcase
  end

  mdio_clkgen #(.DIV_W(DIV_W)) i_clkgen (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (eng_busy),
    .half_i (cfg_half_q),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_engine i_engine (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (launch),
    .pre_en_i  (cfg_pre_q),
    .is_rd_i   (cmd_rd),
    .frame_i   (frame),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .busy_o    (eng_busy),
    .done_o    (eng_done),
    .ta_ok_o   (eng_ta_ok),
    .rx_o      (eng_rx),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic mdc_o,
  input logic mdio_oe_o,
  input logic wr_pend,
  input logic rd_pend,
  input logic rd_valid,
  input logic busy
);
  // R2
  idle_mdc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_pend || rd_pend) |-> !mdc_o);

  // R2
  mdc_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mdc_o |-> busy);

  // R8
  idle_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_pend || rd_pend) |-> !mdio_oe_o);

  // R10
  one_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_pend && rd_pend));

  // R8
  launch_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rd_pend) |-> !rd_valid);

  // R7
  wr_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_pend) |-> !busy);
endmodule

bind mdio_master mdio_master_chk i_mdio_master_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mdc_o     (mdc_o),
  .mdio_oe_o (mdio_oe_o),
  .wr_pend   (wr_pend_q),
  .rd_pend   (rd_pend_q),
  .rd_valid  (rd_valid_q),
  .busy      (eng_busy)
);

// File: tb/test_mdio_master.sv
module test_mdio_master;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = '0, rdata;
  logic        mdc, mdio_out, mdio_oe, mdio_in = 1'b1;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [63:0] cap = '0;
  int          cap_n = 0;
  logic [15:0] phy_data = '0;
  logic        phy_ta2 = 1'b0;

  always #10 clk = ~clk;

  mdio_master i_mdio_master (
    .clk_i(clk), .rst_ni(rst_n), .csr_we_i(we), .csr_addr_i(addr),
    .csr_wdata_i(wdata), .csr_rdata_o(rdata), .mdc_o(mdc),
    .mdio_o(mdio_out), .mdio_oe_o(mdio_oe), .mdio_i(mdio_in));

  // capture bits the master drives
  initial forever begin
    @(posedge mdc); #1;
    if (mdio_oe) begin cap = {cap[62:0], mdio_out}; cap_n++; end
  end

  // PHY response after each falling MDC
  initial begin
    int k = 0;
    forever begin
      @(negedge mdc); #1;
      if (mdio_oe) begin k = 0; mdio_in = 1'b1; end
      else begin
        if (k == 0) mdio_in = 1'b1;
        else if (k == 1) mdio_in = phy_ta2;
        else if (k < 18) mdio_in = phy_data[17-k];
        else mdio_in = 1'b1;
        k++;
      end
    end
  end

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0; wdata = '0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] w, r;
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      csr_rd(2'd1, w); csr_rd(2'd3, r);
      if (!w[16] && !r[17]) break;
    end
  endtask

  function automatic logic [31:0] exp_frame(input logic [1:0] st, input logic [1:0] op,
      input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
    return {st, op, p, r, 2'b10, d};
  endfunction

  function automatic logic [31:0] cmd(input logic [1:0] op, input logic [4:0] p, input logic [4:0] r);
    return {11'd0, r, 3'd0, p, 6'd0, op};
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    csr_rd(2'd0, d); check(d == 0, "R1 cfg", d, 0);
    csr_rd(2'd1, d); check(d == 0, "R1 wdat", d, 0);
    csr_rd(2'd2, d); check(d == 0, "R11 cmd reads 0", d, 0);
    csr_rd(2'd3, d); check(d == 0, "R1 rdat", d, 0);
    check({mdc, mdio_oe, mdio_out} == 3'b001, "R1 pins", {mdc, mdio_oe, mdio_out}, 3'b001);
  endtask

  task automatic t_c22_write();
    logic [31:0] d;
    csr_wr(2'd0, 32'h0000_0202);   // c22, preamble, half 2
    csr_rd(2'd0, d); check(d == 32'h202, "R11 cfg readback", d, 32'h202);
    csr_wr(2'd1, 32'h0000_A5C3);
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd0, 5'd5, 5'h11));
    csr_rd(2'd1, d); check(d[16] == 1'b1, "R7 pending set", d, 32'h1A5C3);
    wait_idle();
    check(cap_n == 64, "R3 preamble+frame bits", cap_n, 64);
    check(cap == {32'hFFFF_FFFF, exp_frame(2'b01, 2'b01, 5'd5, 5'h11, 16'hA5C3)},
          "R4 R6 c22 write frame", cap, {32'hFFFF_FFFF, exp_frame(2'b01, 2'b01, 5'd5, 5'h11, 16'hA5C3)});
    csr_rd(2'd1, d); check(d == 32'h0000_A5C3, "R7 pending cleared", d, 32'hA5C3);
  endtask

  task automatic t_c22_read();
    logic [31:0] d;
    phy_data = 16'hB7E1; phy_ta2 = 1'b0;
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd1, 5'd3, 5'h02));
    csr_rd(2'd3, d); check(d[17:16] == 2'b10, "R8 read pending, valid cleared", d[17:16], 2'b10);
    wait_idle();
    check(cap_n == 46, "R8 release at turnaround", cap_n, 46);
    check(cap[45:0] == {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'h02}, "R4 c22 read header",
          cap[45:0], {32'hFFFF_FFFF, 2'b01, 2'b10, 5'd3, 5'h02});
    csr_rd(2'd3, d); check(d == 32'h0001_B7E1, "R8 read data valid", d, 32'h1B7E1);
  endtask

  task automatic t_c45_seq();
    logic [31:0] d;
    csr_wr(2'd0, 32'h0000_0201);   // c45, no preamble
    csr_wr(2'd1, 32'h0000_1234);
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd0, 5'd9, 5'd3));
    wait_idle();
    check(cap_n == 32, "R3 no preamble", cap_n, 32);
    check(cap[31:0] == exp_frame(2'b00, 2'b00, 5'd9, 5'd3, 16'h1234), "R5 c45 address frame",
          cap[31:0], exp_frame(2'b00, 2'b00, 5'd9, 5'd3, 16'h1234));
    csr_wr(2'd1, 32'h0000_8001);
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd1, 5'd9, 5'd3));
    wait_idle();
    check(cap[31:0] == exp_frame(2'b00, 2'b01, 5'd9, 5'd3, 16'h8001), "R5 R6 c45 write frame",
          cap[31:0], exp_frame(2'b00, 2'b01, 5'd9, 5'd3, 16'h8001));
    phy_data = 16'h4C2D;
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd2, 5'd1, 5'd30));
    wait_idle();
    check(cap_n == 14 && cap[13:0] == {2'b00, 2'b10, 5'd1, 5'd30}, "R5 c45 read-inc header",
          cap[13:0], {2'b00, 2'b10, 5'd1, 5'd30});
    csr_rd(2'd3, d); check(d == 32'h0001_4C2D, "R8 c45 read-inc data", d, 32'h14C2D);
    phy_data = 16'h0F0F;
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd3, 5'd31, 5'd1));
    wait_idle();
    check(cap[13:0] == {2'b00, 2'b11, 5'd31, 5'd1}, "R5 c45 read header",
          cap[13:0], {2'b00, 2'b11, 5'd31, 5'd1});
    csr_rd(2'd3, d); check(d == 32'h0001_0F0F, "R8 c45 read data", d, 32'h10F0F);
  endtask

  task automatic t_ta_err();
    logic [31:0] d;
    phy_data = 16'h5555; phy_ta2 = 1'b1;
    csr_wr(2'd2, cmd(2'd3, 5'd2, 5'd1));
    wait_idle();
    csr_rd(2'd3, d); check(d[17:16] == 2'b00, "R9 turnaround fault clears valid", d[17:16], 2'b00);
    phy_ta2 = 1'b0;
  endtask

  task automatic t_ignore();
    logic [31:0] d;
    phy_data = 16'hC0DE;
    csr_wr(2'd2, cmd(2'd3, 5'd2, 5'd1));
    wait_idle();
    csr_wr(2'd1, 32'h0000_7E57);
    cap_n = 0;
    csr_wr(2'd2, cmd(2'd1, 5'd4, 5'd4));     // write, launches
    csr_wr(2'd2, cmd(2'd3, 5'd6, 5'd6));     // read during frame, ignored
    csr_rd(2'd3, d); check(d == 32'h0001_C0DE, "R10 read status untouched while busy", d, 32'h1C0DE);
    wait_idle();
    check(cap_n == 32 && cap[31:0] == exp_frame(2'b00, 2'b01, 5'd4, 5'd4, 16'h7E57),
          "R10 only first frame sent", cap[31:0], exp_frame(2'b00, 2'b01, 5'd4, 5'd4, 16'h7E57));
    repeat (20) @(negedge clk);
    check(mdc == 1'b0 && cap_n == 32, "R10 no late frame", cap_n, 32);
    csr_rd(2'd3, d); check(d == 32'h0001_C0DE, "R10 read status after", d, 32'h1C0DE);
  endtask

  task automatic t_divider();
    longint t0, t1, t2;
    csr_wr(2'd0, 32'h0000_0301);   // half 3
    csr_wr(2'd2, cmd(2'd1, 5'd1, 5'd1));
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    @(posedge mdc); t2 = $time;
    check((t1 - t0) == 60, "R2 high phase 3 clocks", t1 - t0, 60);
    check((t2 - t1) == 60, "R2 low phase 3 clocks", t2 - t1, 60);
    wait_idle();
    csr_wr(2'd0, 32'h0000_0001);   // half 0 -> 1
    csr_wr(2'd2, cmd(2'd1, 5'd1, 5'd1));
    @(posedge mdc); t0 = $time;
    @(negedge mdc); t1 = $time;
    check((t1 - t0) == 20, "R2 zero half-period acts as 1", t1 - t0, 20);
    wait_idle();
    repeat (5) @(negedge clk);
    check(mdc == 1'b0 && mdio_oe == 1'b0, "R2 idle MDC low", {mdc, mdio_oe}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_c22_write();
    t_c22_read();
    t_c45_seq();
    t_ta_err();
    t_ignore();
    t_divider();
    summary();
  end
endmodule